// File: doc/BRIEF.md
# Multi-path pipeline hazard interlock

This block sits beside the decode stage of a 32-bit in-order pipeline. Behind a separate register-read stage, the back end splits into three paths of different lengths. An integer add goes through one execute stage and then write-back. A load or store goes through the execute stage, two memory stages and then write-back. A floating-point add goes through three FP stages and then write-back. The block records every instruction that leaves decode, with its destination register, path and current stage. From this record it decides whether the instruction now in decode can move on, and the answer depends on the stage at which each source operand is first consumed.

A static input selects one of two policies. With forwarding off, a consumer waits until the producer's write-back lines up with the consumer's register read. The register file writes in the first half of a cycle and reads in the second half, so a read in the same cycle as the write sees the new value. With forwarding on, a consumer waits only until the result exists at the stage where the consumer needs it. For a store, the address is needed at the execute stage and the data only at the first memory stage. When decode is held, a bubble goes into register read. In forwarding mode the block also gives, for each operand, a hint naming the producer's path and stage from which the value is taken. The register file has unlimited write ports, so the block never stalls for a write-port conflict.

Top module: `hzd_interlock`

## Requirements
- R1: Codes on `dec_op_i`: 0 no-op, 1 integer add, 2 load, 3 store, 4 FP add. Integer add and FP add read operands A and B. A load reads A as its address. A store reads A as its address and B as its data. Integer add, load and FP add write `dec_dst_i`. `stall_o` is 0 whenever `dec_valid_i` is 0, and a cycle with `dec_valid_i` low never records a producer.
- R2: With `byp_en_i`=0, an operand stalls decode until its producer's write-back cycle is no later than the cycle in which the consumer would sit in register read. Back-to-back dependent pairs therefore give 1 stall cycle after an integer add, and 3 after an FP add or a load.
- R3: With `byp_en_i`=1, an ALU operand or store address is needed at the first stage after register read, and store data at the second. A result exists after the execute stage for an integer add, after the second memory stage for a load, and after the third FP stage for an FP add. Back-to-back stall counts: integer to integer 0, FP to FP 2, load to store address 2, load to store data 1, FP to store data 1.
- R4: Register 0 never creates a dependence. A store or a no-op never acts as a producer, whatever is on `dec_dst_i`.
- R5: When several in-flight instructions write the same register, only the youngest one decides the stall and the hint.
- R6: While `stall_o` is 1, the held instruction is not recorded. A bubble enters register read instead, so an instruction whose destination equals its own source waits only on the older producer.
- R7: With `byp_en_i`=1 and no stall, `fwd_x_o` is 1 when the youngest producer of operand X will not yet have written the register file by the consumer's register-read cycle. `fwd_x_path_o` then gives the producer's path (0 integer, 1 load, 2 FP). `fwd_x_pos_o` gives the producer's stage at pickup, where 1 is the first stage after register read and write-back is 2 for integer and 4 for load and FP. Pickup is at the first stage after register read. For store data, pickup is at the second stage unless the value already exists at the first.
- R8: All hint outputs are 0 when `byp_en_i` is 0, when `stall_o` is 1, when `dec_valid_i` is 0, or when the operand is not read by the opcode.
- R9: Reset clears every recorded producer, so the first instruction after reset never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byp_en_i | input | 1 | Static policy select: 1 forwarding, 0 none |
| dec_valid_i | input | 1 | Decode holds an instruction |
| dec_op_i | input | 3 | Opcode class (R1) |
| dec_dst_i | input | 5 | Destination register |
| dec_src_a_i | input | 5 | Operand A register |
| dec_src_b_i | input | 5 | Operand B register |
| stall_o | output | 1 | Hold decode and insert a bubble |
| fwd_a_o | output | 1 | Operand A taken by forwarding |
| fwd_a_path_o | output | 2 | Path of operand A producer |
| fwd_a_pos_o | output | 3 | Producer stage at pickup for A |
| fwd_b_o | output | 1 | Operand B taken by forwarding |
| fwd_b_path_o | output | 2 | Path of operand B producer |
| fwd_b_pos_o | output | 3 | Producer stage at pickup for B |

## Verification
The two store operands are checked against separate deadlines, and in the same decode cycle they can resolve against two different producers. The bench provokes this with a load, then an FP add, then a store that takes its address from the load and its data from the FP add. It requires exactly one stall cycle, then both hints in the release cycle, each with its own path and stage. The bench also checks the youngest-producer rule in the same cycle as a shadowed older producer. An older FP add that would still force a stall must be ignored in favour of a younger integer add to the same register.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_IADD  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_FADD  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PATH_INT = 2'd0,
    PATH_MEM = 2'd1,
    PATH_FP  = 2'd2
  } path_e;

  // stage (1 = first after regread) at whose end the result exists
  function automatic int prod_pos(logic [1:0] p, int mem_st, int fp_st);
    case (p)
      PATH_MEM: return 1 + mem_st;
      PATH_FP:  return fp_st;
      default:  return 1;
    endcase
  endfunction

  function automatic int wb_pos(logic [1:0] p, int mem_st, int fp_st);
    return prod_pos(p, mem_st, fp_st) + 1;
  endfunction

endpackage

// File: rtl/hzd_track.sv
module hzd_track
  import hzd_pkg::*;
#(
  parameter int RW         = 5,
  parameter int DEPTH      = 4,
  parameter int MEM_STAGES = 2,
  parameter int FP_STAGES  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [RW-1:0]             push_dst_i,
  input  logic [1:0]                push_path_i,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][RW-1:0]  dst_o,
  output logic [DEPTH-1:0][1:0]     path_o
);

  // slot i = producer i stages past regread (0 = in regread)
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_o[0]  <= 1'b0;
          dst_o[0]  <= '0;
          path_o[0] <= '0;
        end else begin
          vld_o[0]  <= push_i;
          dst_o[0]  <= push_dst_i;
          path_o[0] <= push_path_i;
        end
      end
    end else begin : g_body
      logic alive;
      // a producer drops out once it reaches write-back
      assign alive = vld_o[i-1] && (i < wb_pos(path_o[i-1], MEM_STAGES, FP_STAGES));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_o[i]  <= 1'b0;
          dst_o[i]  <= '0;
          path_o[i] <= '0;
        end else begin
          vld_o[i]  <= alive;
          dst_o[i]  <= dst_o[i-1];
          path_o[i] <= path_o[i-1];
        end
      end
    end
  end

endmodule

// File: rtl/hzd_src_chk.sv
module hzd_src_chk
  import hzd_pkg::*;
#(
  parameter int RW         = 5,
  parameter int DEPTH      = 4,
  parameter int POS_W      = 3,
  parameter int MEM_STAGES = 2,
  parameter int FP_STAGES  = 3
) (
  input  logic [DEPTH-1:0]          vld_i,
  input  logic [DEPTH-1:0][RW-1:0]  dst_i,
  input  logic [DEPTH-1:0][1:0]     path_i,
  input  logic [RW-1:0]             src_i,
  input  logic                      use_i,
  input  logic                      data_i,
  input  logic                      byp_en_i,
  output logic                      stall_o,
  output logic                      fwd_o,
  output logic [1:0]                fwd_path_o,
  output logic [POS_W-1:0]          fwd_pos_o
);

  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = use_i && (src_i != '0) && vld_i[i] && (dst_i[i] == src_i);
  end

  logic       hit;
  logic [1:0] hpath;
  int         hp, prod, wb, need, neff;
  logic       late_rf;

  always_comb begin
    hit   = 1'b0;
    hp    = 0;
    hpath = '0;
    // youngest producer (lowest slot) wins
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        hp    = i;
        hpath = path_i[i];
      end
    end
    prod    = prod_pos(hpath, MEM_STAGES, FP_STAGES);
    wb      = prod + 1;
    need    = data_i ? 2 : 1;
    neff    = (hp + 1 >= prod) ? 1 : need;
    late_rf = hit && (hp + 1 < wb);
    if (byp_en_i) stall_o = hit && (hp + need < prod);
    else          stall_o = late_rf;
    fwd_o      = byp_en_i && late_rf && !stall_o;
    fwd_path_o = fwd_o ? hpath : 2'd0;
    fwd_pos_o  = fwd_o ? POS_W'(hp + 1 + neff) : '0;
  end

endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter  int NUM_REGS   = 32,
  parameter  int MEM_STAGES = 2,
  parameter  int FP_STAGES  = 3,
  localparam int RW         = $clog2(NUM_REGS),
  localparam int WB_MEM     = MEM_STAGES + 2,
  localparam int WB_FP      = FP_STAGES + 1,
  localparam int DEPTH      = (WB_MEM > WB_FP) ? WB_MEM : WB_FP,
  localparam int POS_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byp_en_i,
  input  logic             dec_valid_i,
  input  logic [2:0]       dec_op_i,
  input  logic [RW-1:0]    dec_dst_i,
  input  logic [RW-1:0]    dec_src_a_i,
  input  logic [RW-1:0]    dec_src_b_i,
  output logic             stall_o,
  output logic             fwd_a_o,
  output logic [1:0]       fwd_a_path_o,
  output logic [POS_W-1:0] fwd_a_pos_o,
  output logic             fwd_b_o,
  output logic [1:0]       fwd_b_path_o,
  output logic [POS_W-1:0] fwd_b_pos_o
);

  op_e op;
  assign op = op_e'(dec_op_i);

  logic             writes;
  logic [1:0]       path;
  logic [1:0]       use_v, data_v;
  logic [1:0][RW-1:0] src_v;

  always_comb begin
    writes = 1'b0;
    path   = PATH_INT;
    use_v  = 2'b00;
    data_v = 2'b00;
    case (op)
      OP_IADD:  begin writes = 1'b1; path = PATH_INT; use_v = 2'b11; end
      OP_LOAD:  begin writes = 1'b1; path = PATH_MEM; use_v = 2'b01; end
      OP_STORE: begin use_v = 2'b11; data_v = 2'b10; end
      OP_FADD:  begin writes = 1'b1; path = PATH_FP;  use_v = 2'b11; end
      default:  ;
    endcase
  end

  assign src_v[0] = dec_src_a_i;
  assign src_v[1] = dec_src_b_i;

  logic [DEPTH-1:0]         trk_vld;
  logic [DEPTH-1:0][RW-1:0] trk_dst;
  logic [DEPTH-1:0][1:0]    trk_path;

  logic [1:0]              s_stall, s_fwd;
  logic [1:0][1:0]         s_path;
  logic [1:0][POS_W-1:0]   s_pos;

  for (genvar g = 0; g < 2; g++) begin : g_src
    hzd_src_chk #(
      .RW(RW), .DEPTH(DEPTH), .POS_W(POS_W),
      .MEM_STAGES(MEM_STAGES), .FP_STAGES(FP_STAGES)
    ) u_chk (
      .vld_i      (trk_vld),
      .dst_i      (trk_dst),
      .path_i     (trk_path),
      .src_i      (src_v[g]),
      .use_i      (use_v[g]),
      .data_i     (data_v[g]),
      .byp_en_i   (byp_en_i),
      .stall_o    (s_stall[g]),
      .fwd_o      (s_fwd[g]),
      .fwd_path_o (s_path[g]),
      .fwd_pos_o  (s_pos[g])
    );
  end

  assign stall_o = dec_valid_i && (|s_stall);

  logic go;
  assign go = dec_valid_i && !stall_o;

  assign fwd_a_o      = go && s_fwd[0];
  assign fwd_a_path_o = (go && s_fwd[0]) ? s_path[0] : 2'd0;
  assign fwd_a_pos_o  = (go && s_fwd[0]) ? s_pos[0]  : '0;
  assign fwd_b_o      = go && s_fwd[1];
  assign fwd_b_path_o = (go && s_fwd[1]) ? s_path[1] : 2'd0;
  assign fwd_b_pos_o  = (go && s_fwd[1]) ? s_pos[1]  : '0;

  // stalled cycles push a bubble into regread
  hzd_track #(
    .RW(RW), .DEPTH(DEPTH), .MEM_STAGES(MEM_STAGES), .FP_STAGES(FP_STAGES)
  ) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (go && writes && (dec_dst_i != '0)),
    .push_dst_i  (dec_dst_i),
    .push_path_i (path),
    .vld_o       (trk_vld),
    .dst_o       (trk_dst),
    .path_o      (trk_path)
  );

endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
  parameter int RW    = 5,
  parameter int DEPTH = 4,
  parameter int POS_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byp_en_i,
  input logic             dec_valid_i,
  input logic [RW-1:0]    dec_src_a_i,
  input logic [RW-1:0]    dec_src_b_i,
  input logic             stall_o,
  input logic             fwd_a_o,
  input logic [POS_W-1:0] fwd_a_pos_o,
  input logic             fwd_b_o,
  input logic [POS_W-1:0] fwd_b_pos_o,
  input logic [DEPTH-1:0] slot_vld_i
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_idle_no_stall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !stall_o);

  p_zero_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_src_a_i == '0 && dec_src_b_i == '0) |-> !stall_o);

  p_bubble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !slot_vld_i[0]);

  p_fwd_pos_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_a_o |-> (fwd_a_pos_o != '0 && int'(fwd_a_pos_o) <= DEPTH));

  p_fwd_pos_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_b_o |-> (fwd_b_pos_o != '0 && int'(fwd_b_pos_o) <= DEPTH));

  p_quiet_hint_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o || !byp_en_i || !dec_valid_i) |-> !(fwd_a_o || fwd_b_o));

  p_reset_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (slot_vld_i == '0));

endmodule

bind hzd_interlock hzd_interlock_chk #(.RW(RW), .DEPTH(DEPTH), .POS_W(POS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byp_en_i    (byp_en_i),
  .dec_valid_i (dec_valid_i),
  .dec_src_a_i (dec_src_a_i),
  .dec_src_b_i (dec_src_b_i),
  .stall_o     (stall_o),
  .fwd_a_o     (fwd_a_o),
  .fwd_a_pos_o (fwd_a_pos_o),
  .fwd_b_o     (fwd_b_o),
  .fwd_b_pos_o (fwd_b_pos_o),
  .slot_vld_i  (trk_vld)
);

// File: tb/hzd_interlock_tb.sv
module hzd_interlock_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byp_en_i = 1'b0;
  logic       dec_valid_i = 1'b0;
  logic [2:0] dec_op_i = '0;
  logic [4:0] dec_dst_i = '0, dec_src_a_i = '0, dec_src_b_i = '0;
  logic       stall_o, fwd_a_o, fwd_b_o;
  logic [1:0] fwd_a_path_o, fwd_b_path_o;
  logic [2:0] fwd_a_pos_o, fwd_b_pos_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  hzd_interlock u_dut (
    .clk_i, .rst_ni, .byp_en_i, .dec_valid_i, .dec_op_i, .dec_dst_i,
    .dec_src_a_i, .dec_src_b_i, .stall_o, .fwd_a_o, .fwd_a_path_o,
    .fwd_a_pos_o, .fwd_b_o, .fwd_b_path_o, .fwd_b_pos_o
  );

  typedef logic [12:0] item_t; // stall, fa, pa, qa, fb, pb, qb
  item_t exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // monitor: compare away from the active edge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      item_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {stall_o, fwd_a_o, fwd_a_path_o, fwd_a_pos_o, fwd_b_o, fwd_b_path_o, fwd_b_pos_o};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual stall/fa/pa/qa/fb/pb/qb=%b expected %b", t, a, e);
      end
    end
  end

  task automatic push(input item_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic issue(input int op, input int dst, input int sa, input int sb,
                       input int nst, input int fa, input int pa, input int qa,
                       input int fb, input int pb, input int qb, input string t);
    dec_valid_i = 1'b1;
    dec_op_i    = 3'(op);
    dec_dst_i   = 5'(dst);
    dec_src_a_i = 5'(sa);
    dec_src_b_i = 5'(sb);
    for (int k = 0; k <= nst; k++) begin
      if (k < nst) push(13'b1_0_00_000_0_00_000, t);
      else push({1'b0, 1'(fa), 2'(pa), 3'(qa), 1'(fb), 2'(pb), 3'(qb)}, t);
      step();
    end
    dec_valid_i = 1'b0;
  endtask

  task automatic idle(input int n, input string t);
    dec_valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      push('0, t);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    idle(2, "R9 reset state");

    // ---- no forwarding ----
    byp_en_i = 1'b0;
    issue(1, 1, 5, 6, 0, 0,0,0, 0,0,0, "R2 int producer");
    issue(1, 2, 1, 3, 1, 0,0,0, 0,0,0, "R2 int->int 1 stall");
    idle(5, "R2 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R2 fp producer");
    issue(4, 5, 4, 12, 3, 0,0,0, 0,0,0, "R2 fp->fp 3 stalls");
    idle(5, "R2 flush");
    issue(2, 7, 1, 0, 0, 0,0,0, 0,0,0, "R2 load producer");
    issue(3, 0, 7, 8, 3, 0,0,0, 0,0,0, "R2 load->store addr 3 stalls");
    idle(5, "R2 flush");
    issue(1, 0, 5, 6, 0, 0,0,0, 0,0,0, "R4 int to r0");
    issue(1, 9, 0, 0, 0, 0,0,0, 0,0,0, "R4 reads r0 no stall");
    issue(3, 9, 1, 2, 0, 0,0,0, 0,0,0, "R4 store with dst field");
    issue(1, 10, 9, 9, 0, 0,0,0, 0,0,0, "R4 store is no producer");
    idle(5, "R4 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R6 fp producer");
    issue(4, 4, 4, 12, 3, 0,0,0, 0,0,0, "R6 self dst=src waits 3 only");
    idle(5, "R6 flush");
    issue(1, 3, 5, 6, 0, 0,0,0, 0,0,0, "R1 producer");
    dec_op_i = 3'd1; dec_src_a_i = 5'd3; dec_src_b_i = 5'd3;
    idle(1, "R1 invalid slot never stalls");
    idle(5, "R1 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R9 producer before reset");
    rst_ni = 1'b0;
    #(CLK_PERIOD);
    rst_ni = 1'b1;
    issue(1, 6, 4, 4, 0, 0,0,0, 0,0,0, "R9 reset cleared producer");
    idle(5, "R9 flush");

    // ---- full forwarding ----
    byp_en_i = 1'b1;
    issue(1, 1, 5, 6, 0, 0,0,0, 0,0,0, "R3 int producer");
    issue(1, 2, 1, 3, 0, 1,0,2, 0,0,0, "R3 R7 int->int 0 stall fwd");
    idle(5, "R3 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R3 fp producer");
    issue(4, 5, 12, 4, 2, 0,0,0, 1,2,4, "R3 R7 fp->fp 2 stalls");
    idle(5, "R3 flush");
    issue(2, 7, 1, 0, 0, 0,0,0, 0,0,0, "R3 load producer");
    issue(3, 0, 7, 8, 2, 1,1,4, 0,0,0, "R3 R7 load->store addr 2 stalls");
    idle(5, "R3 flush");
    issue(2, 7, 1, 0, 0, 0,0,0, 0,0,0, "R3 load producer");
    issue(3, 0, 9, 7, 1, 0,0,0, 1,1,4, "R3 R7 load->store data 1 stall");
    idle(5, "R3 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R3 fp producer");
    issue(3, 0, 9, 4, 1, 0,0,0, 1,2,4, "R3 R7 fp->store data 1 stall");
    idle(5, "R3 flush");
    issue(1, 5, 10, 11, 0, 0,0,0, 0,0,0, "R7 int producer");
    issue(3, 0, 9, 5, 0, 0,0,0, 1,0,2, "R7 store data early pickup");
    idle(5, "R7 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R5 older fp");
    issue(1, 4, 12, 13, 0, 0,0,0, 0,0,0, "R5 younger int");
    issue(1, 14, 4, 15, 0, 1,0,2, 0,0,0, "R5 youngest decides");
    idle(5, "R5 flush");
    issue(1, 1, 5, 6, 0, 0,0,0, 0,0,0, "R7 int producer one");
    issue(1, 2, 7, 8, 0, 0,0,0, 0,0,0, "R7 int producer two");
    issue(1, 3, 1, 2, 0, 0,0,0, 1,0,2, "R7 A from regfile B forwarded");
    idle(5, "R7 flush");
    issue(2, 7, 1, 0, 0, 0,0,0, 0,0,0, "R3 load producer");
    issue(4, 8, 10, 11, 0, 0,0,0, 0,0,0, "R3 fp producer");
    issue(3, 0, 7, 8, 1, 1,1,4, 1,2,4, "R3 store two deadlines");
    idle(5, "R3 flush");
    issue(2, 7, 1, 0, 0, 0,0,0, 0,0,0, "R8 load producer");
    issue(2, 9, 1, 7, 0, 0,0,0, 0,0,0, "R8 load ignores operand B");
    issue(0, 0, 9, 9, 0, 0,0,0, 0,0,0, "R4 no-op never stalls");
    idle(5, "R8 flush");
    issue(4, 4, 10, 11, 0, 0,0,0, 0,0,0, "R6 fp producer");
    issue(4, 4, 4, 12, 2, 1,2,4, 0,0,0, "R6 self dst=src bypass");
    idle(5, "R6 flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule